// File: doc/BRIEF.md
# Programmable Multi-Level Interrupt Arbiter

This block sits between a set of peripheral interrupt sources and a processor core. Each source carries a programmed priority level and a subpriority, written through a small configuration port. Every cycle the arbiter picks the most urgent pending, enabled source. It raises a request with that source's vector number only when the winner's level is strictly above the level the processor is currently running at. A group of trap inputs sits above every user level, so a trap is always taken ahead of ordinary interrupts.

The processor accepts a request with an acknowledge pulse. The arbiter then saves the running level on an internal stack and adopts the winner's level. A higher-level source can therefore preempt the handler, while equal or lower sources wait. A return pulse restores the saved level. An optional no-nesting mode raises the running level to the top user level on every accepted user interrupt, so no further user interrupt can nest until return. A wake indication flags any live request, whatever the running level is.

Top module: `prio_intr_arb`

## Requirements
- R1: A source programmed to level 0 never wins arbitration and never asserts `wake`, even when pending and enabled.
- R2: After reset every source holds level 4 and subpriority 0, and `cpu_lvl` is 0.
- R3: The highest level among candidates wins. Trap input j has level 8+j and vector j. User source i has vector NTRAP+i (4+i by default), so every pending trap beats every user source.
- R4: Among candidates of equal level, the one with the larger subpriority (0 to 3) wins.
- R5: Among candidates of equal level and equal subpriority, the lowest source index wins.
- R6: `irq_req` is high only when the winner's level is strictly greater than `cpu_lvl`. `irq_lvl` and `irq_vec` then report that winner.
- R7: An `ack` while `irq_req` is high saves `cpu_lvl` and loads the winner's level, so only a strictly higher level can request next.
- R8: A `ret` restores the most recently saved level. A `ret` with nothing saved leaves `cpu_lvl` unchanged. When `ret` and `ack` arrive in the same cycle, the `ret` is performed and the `ack` is dropped.
- R9: With `nest_dis` high, acknowledging a user source sets `cpu_lvl` to 7, the top user level. Acknowledging a trap still sets its own trap level.
- R10: An `ack` while `irq_req` is low has no effect on `cpu_lvl`.
- R11: A source whose enable bit is low is not a candidate.
- R12: `wake` is high when any trap is pending, or any enabled pending source has a nonzero level, regardless of `cpu_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NSRC | Per-source pending flags |
| src_en | input | NSRC | Per-source enable bits |
| trap_pend | input | NTRAP | Trap inputs, higher index is more urgent |
| cfg_we | input | 1 | Write strobe for a source's level and subpriority |
| cfg_idx | input | IDXW | Source being written |
| cfg_lvl | input | LW | New level (0 disables the source) |
| cfg_sub | input | SW | New subpriority |
| nest_dis | input | 1 | No-nesting mode for user interrupts |
| ack | input | 1 | Processor accepts the current request |
| ret | input | 1 | Processor returns from the current handler |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | VW | Vector number of the winner |
| irq_lvl | output | LW+1 | Level of the winner |
| cpu_lvl | output | LW+1 | Running processor level |
| wake | output | 1 | A live request exists at any level |

## Verification
The arbitration table applies a fixed set of levels and subpriorities and walks through pending/enable patterns. Each pattern isolates one ordering rule: a plain level win, a subpriority tie-break, a full tie settled by index, a masked source, and a disabled level-0 source. Directed sequences then build a nested stack through a user preemption and two traps, and unwind it past the empty point. These sequences tell a push-and-adopt update apart from a plain level compare, and a same-cycle return apart from an acknowledge. A no-nesting pass shows that an equal user level is blocked while a trap still gets through. A final reconfiguration of a disabled source shows that level writes take effect.

// File: rtl/prio_intr_arb.sv
module prio_intr_arb #(
  parameter int NSRC  = 8,
  parameter int NTRAP = 4,
  parameter int LW    = 3,
  parameter int SW    = 2,
  parameter int DEPTH = 16,
  parameter int IDXW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int VW    = $clog2(NTRAP + NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NTRAP-1:0] trap_pend,
  input  logic             cfg_we,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [LW-1:0]    cfg_lvl,
  input  logic [SW-1:0]    cfg_sub,
  input  logic             nest_dis,
  input  logic             ack,
  input  logic             ret,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  output logic [LW:0]      irq_lvl,
  output logic [LW:0]      cpu_lvl,
  output logic             wake
);
  localparam int CW  = LW + 1;
  localparam int IW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] TOPU   = CW'((1 << LW) - 1);
  localparam logic [CW-1:0] TBASE  = CW'(1 << LW);
  localparam logic [LW-1:0] LVL_RST = LW'(4);
  localparam logic [VW-1:0] VUSER  = VW'(NTRAP);

  logic [LW-1:0]  lvl_q [NSRC];
  logic [SW-1:0]  sub_q [NSRC];
  logic [CW-1:0]  stk   [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_m1;

  logic           found;
  logic           win_trap;
  logic [CW-1:0]  best_l;
  logic [SW-1:0]  best_s;
  logic [VW-1:0]  best_v;

  logic push, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        lvl_q[i] <= LVL_RST;
        sub_q[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_idx == IDXW'(i)) begin
          lvl_q[i] <= cfg_lvl;
          sub_q[i] <= cfg_sub;
        end
      end
    end
  end

  always_comb begin
    found    = 1'b0;
    win_trap = 1'b0;
    best_l   = '0;
    best_s   = '0;
    best_v   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_pend[i] && src_en[i] && lvl_q[i] != '0) begin
        if (!found || {1'b0, lvl_q[i]} > best_l ||
            ({1'b0, lvl_q[i]} == best_l && sub_q[i] > best_s)) begin
          found  = 1'b1;
          best_l = {1'b0, lvl_q[i]};
          best_s = sub_q[i];
          best_v = VW'(NTRAP + i);
        end
      end
    end
    for (int j = 0; j < NTRAP; j++) begin
      if (trap_pend[j]) begin
        found    = 1'b1;
        win_trap = 1'b1;
        best_l   = TBASE + CW'(j);
        best_s   = '0;
        best_v   = VW'(j);
      end
    end
  end

  assign irq_req = found && (best_l > cpu_lvl);
  assign irq_vec = best_v;
  assign irq_lvl = best_l;
  assign wake    = found;

  assign sp_m1 = sp - 1'b1;
  assign pop   = ret && (sp != '0);
  assign push  = !ret && ack && irq_req && (sp < SPW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_lvl <= '0;
      sp      <= '0;
    end else if (pop) begin
      cpu_lvl <= stk[sp_m1[IW-1:0]];
      sp      <= sp_m1;
    end else if (push) begin
      cpu_lvl <= (nest_dis && !win_trap) ? TOPU : best_l;
      sp      <= sp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk[sp[IW-1:0]] <= cpu_lvl;
  end

  // R1
  lvl0_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec >= VUSER) |-> irq_lvl != '0);

  // R3
  trap_over_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trap_pend) && cpu_lvl < TBASE) |-> (irq_req && irq_vec < VUSER && irq_lvl >= TBASE));

  // R7
  ack_adopts_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !ret && !nest_dis) |=> cpu_lvl == $past(irq_lvl));

  // R8
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && sp == '0) |=> ($stable(cpu_lvl) && sp == '0));

  // R9
  nest_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !ret && nest_dis && irq_vec >= VUSER) |=> cpu_lvl == TOPU);

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !ret) |=> $stable(cpu_lvl));

  // R7
  stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !ret) |-> sp < SPW'(DEPTH));
endmodule

// File: tb/prio_intr_arb_tb.sv
module prio_intr_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_pend = '0;
  logic [7:0] src_en = '0;
  logic [3:0] trap_pend = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic [1:0] cfg_sub = '0;
  logic       nest_dis = 1'b0;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  logic       irq_req;
  logic [3:0] irq_vec;
  logic [3:0] irq_lvl;
  logic [3:0] cpu_lvl;
  logic       wake;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_intr_arb u_dut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .trap_pend(trap_pend), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .cfg_sub(cfg_sub), .nest_dis(nest_dis),
    .ack(ack), .ret(ret), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .cpu_lvl(cpu_lvl), .wake(wake)
  );

  // {pend, en, exp_req, exp_vec, exp_lvl}
  localparam logic [24:0] TBL [10] = '{
    {8'h01, 8'hFF, 1'b1, 4'd4,  4'd3},  // R3 single source
    {8'h03, 8'hFF, 1'b1, 4'd5,  4'd5},  // R3 higher level
    {8'h07, 8'hFF, 1'b1, 4'd6,  4'd5},  // R4 sub 3 over sub 1
    {8'h17, 8'hFF, 1'b1, 4'd6,  4'd5},  // R5 tie, lowest index
    {8'h08, 8'hFF, 1'b0, 4'd0,  4'd0},  // R1 level 0 source
    {8'h48, 8'hFF, 1'b1, 4'd10, 4'd7},  // R3 level 7
    {8'h40, 8'hBF, 1'b0, 4'd0,  4'd0},  // R11 masked
    {8'h80, 8'hFF, 1'b1, 4'd11, 4'd4},  // R2 default level kept
    {8'h21, 8'hFF, 1'b1, 4'd4,  4'd3},  // R3 level 3 over 2
    {8'h14, 8'hFB, 1'b1, 4'd8,  4'd5}   // R11 masked tie partner
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic cfg(input int idx, input int l, input int s);
    cfg_idx = 3'(idx); cfg_lvl = 3'(l); cfg_sub = 2'(s); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0; #1;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0; #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R2 cpu_lvl reset", cpu_lvl, 0);
    chk("R2 no request", irq_req, 0);
    src_pend = 8'hFF; src_en = 8'hFF; #1;
    chk("R2 default level", irq_lvl, 4);
    chk("R2 equal defaults pick index 0 (R5)", irq_vec, 4);
    src_pend = '0;

    cfg(0, 3, 0); cfg(1, 5, 1); cfg(2, 5, 3); cfg(3, 0, 0);
    cfg(4, 5, 3); cfg(5, 2, 2); cfg(6, 7, 0);

    for (int k = 0; k < 10; k++) begin
      src_pend = TBL[k][24:17];
      src_en   = TBL[k][16:9];
      #1;
      chk($sformatf("R6 table %0d req", k), irq_req, int'(TBL[k][8]));
      if (TBL[k][8]) begin
        chk($sformatf("R3 table %0d vec", k), irq_vec, int'(TBL[k][7:4]));
        chk($sformatf("R3 table %0d lvl", k), irq_lvl, int'(TBL[k][3:0]));
      end
    end

    src_en = 8'hFF;
    src_pend = 8'h08; #1;
    chk("R1 level 0 no wake", wake, 0);
    src_pend = 8'h80; #1;
    chk("R12 wake", wake, 1);

    src_pend = 8'h00; #1;
    pulse_ack();
    chk("R10 idle ack ignored", cpu_lvl, 0);

    src_pend = 8'h01; #1;
    chk("R6 request vec", irq_vec, 4);
    pulse_ack();
    chk("R7 cpu adopts level", cpu_lvl, 3);
    chk("R6 equal level no request", irq_req, 0);
    src_pend = 8'h21; #1;
    chk("R6 lower level no request", irq_req, 0);
    chk("R12 wake independent of cpu level", wake, 1);
    src_pend = 8'h03; #1;
    chk("R7 preempt request", irq_req, 1);
    chk("R7 preempt vec", irq_vec, 5);
    pulse_ack();
    chk("R7 nested level", cpu_lvl, 5);
    trap_pend = 4'b0010; #1;
    chk("R3 trap vec", irq_vec, 1);
    chk("R3 trap lvl", irq_lvl, 9);
    trap_pend = 4'b1010; #1;
    chk("R3 higher trap vec", irq_vec, 3);
    pulse_ack();
    chk("R7 trap level", cpu_lvl, 11);
    trap_pend = '0; src_pend = '0;
    pulse_ret();
    chk("R8 pop to 5", cpu_lvl, 5);
    pulse_ret();
    chk("R8 pop to 3", cpu_lvl, 3);
    pulse_ret();
    chk("R8 pop to 0", cpu_lvl, 0);
    pulse_ret();
    chk("R8 empty return", cpu_lvl, 0);

    src_pend = 8'h01; #1;
    ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0; #1;
    chk("R8 ret beats ack", cpu_lvl, 0);

    nest_dis = 1'b1;
    pulse_ack();
    chk("R9 nest raises to top", cpu_lvl, 7);
    src_pend = 8'h41; #1;
    chk("R9 level 7 blocked", irq_req, 0);
    trap_pend = 4'b0001; #1;
    chk("R9 trap passes", irq_req, 1);
    chk("R9 trap vec", irq_vec, 0);
    pulse_ack();
    chk("R9 trap own level", cpu_lvl, 8);
    trap_pend = '0; src_pend = '0; nest_dis = 1'b0;
    pulse_ret();
    chk("R9 pop to 7", cpu_lvl, 7);
    pulse_ret();
    chk("R9 pop to 0", cpu_lvl, 0);

    cfg(3, 6, 1);
    src_pend = 8'h08; #1;
    chk("R3 reconfigured vec", irq_vec, 7);
    chk("R3 reconfigured lvl", irq_lvl, 6);
    src_pend = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule